// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only byte cache that sits between a requester and a slower block-oriented memory. Each set holds two lines, and a requested byte address may live in either of them. On an access, the set is selected and both stored tags are compared at the same time. If a valid line matches, the block returns the byte from that line. If neither line matches, the block stalls the requester and picks a line to replace. It then fetches the whole block from memory as a stream of bytes, installs it, and answers with the requested byte.

Each set carries a single replacement bit. This bit names the line that will be evicted next. It is refreshed on every hit and on every fill, so the two lines of a set are kept in true least-recently-used order. The widths of the tag, set index and block offset are parameters. A line always holds `2^OFF_W` bytes.

Top module: `cache2way`

## Requirements
- R1: An address is split, from least to most significant bit, into an OFF_W-bit byte offset, an SET_W-bit set index and a TAG_W-bit tag. Lines in different sets never displace one another. The same tag in a different set is a separate block.
- R2: After reset every line is invalid, so the first access to any address misses. While idle, `reqReady` is 1 and both `rspValid` and `memReq` are 0.
- R3: A request is accepted on an edge where `reqValid` and `reqReady` are both 1. On a hit, the next edge raises `rspValid` for exactly one cycle, with `rspHit` = 1 and `rspData` set to the stored byte.
- R4: For any access, at most one of the two lines of the selected set matches.
- R5: On a miss, `memReq` rises with `memAddr` equal to the block address (the request address with its offset bits cleared). Both stay constant until an edge with `memAck` = 1. `reqReady` stays 0 from acceptance until the response.
- R6: After the acknowledge, the block takes `2^OFF_W` bytes on edges where `memDataValid` = 1. Idle cycles are allowed between bytes. The k-th byte received is stored at offset k. The edge that takes the last byte raises `rspValid` for one cycle with `rspHit` = 0 and the requested byte.
- R7: On a miss, an invalid line of the set is filled if one exists, and line 0 is filled when both are invalid.
- R8: On a miss with both lines valid, the least recently used line is replaced. Both a hit and a fill make the touched line the most recently used one.
- R9: Within one set, with distinct tags A, B and C, the sequence A, B, A, C, B, A, B hits only on the third and seventh access.
- R10: `memDataValid` and `memAck` have no effect outside a miss, and stored lines are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Requester presents an address |
| reqAddr | input | TAG_W+SET_W+OFF_W | Byte address to read |
| reqReady | output | 1 | Block is idle and can accept a request |
| rspValid | output | 1 | One-cycle response strobe |
| rspHit | output | 1 | 1 if the response came from a hit, 0 after a fill |
| rspData | output | DATA_W | Requested byte |
| memReq | output | 1 | Block fetch request to memory |
| memAddr | output | TAG_W+SET_W+OFF_W | Block address of the fetch, offset bits zero |
| memAck | input | 1 | Memory accepts the fetch request |
| memDataValid | input | 1 | A fill byte is present on memData |
| memData | input | DATA_W | Fill byte stream, offset 0 first |

## Verification
The bench targets replacement order. If the replacement bit were updated only on fills, the hit-then-miss case would evict the line that was just read, and the known access sequence would gain misses. It streams fill bytes with gaps and asks for a middle offset. A design that counted idle cycles or placed bytes in the wrong slot would return the wrong byte or corrupt neighbouring offsets. It reuses one tag in another set and injects stray memory strobes while idle. A design that compared tags across sets, or that wrote on any `memDataValid`, would then report false hits or return damaged data.

// File: rtl/cache2way_pkg.sv
package cache2way_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FETCH  = 2'd2,
    ST_FILL   = 2'd3
  } ctrlState_t;

  typedef struct packed {
    logic capture;
    logic hitTouch;
    logic missPick;
    logic fillByte;
    logic fillLast;
  } ctrlStrobe_t;
endpackage

// File: rtl/cache2way_dp.sv
module cache2way_dp
  import cache2way_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int SET_W  = 2,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobe_t                    strobe,
  input  logic [TAG_W+SET_W+OFF_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]              memData,
  output logic                           lookupHit,
  output logic                           lastByte,
  output logic [TAG_W+SET_W+OFF_W-1:0]   blockAddr,
  output logic                           rspValid,
  output logic                           rspHit,
  output logic [DATA_W-1:0]              rspData
);
  localparam int ADDR_W = TAG_W + SET_W + OFF_W;
  localparam int SETS   = 1 << SET_W;
  localparam int BYTES  = 1 << OFF_W;
  localparam int WAYS   = 2;
  localparam logic [OFF_W-1:0] OFF_ONE  = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_LAST = '1;

  logic [ADDR_W-1:0] curAddr;
  logic [TAG_W-1:0]  curTag;
  logic [SET_W-1:0]  curSet;
  logic [OFF_W-1:0]  curOff;

  assign curOff = curAddr[OFF_W-1:0];
  assign curSet = curAddr[OFF_W +: SET_W];
  assign curTag = curAddr[ADDR_W-1 -: TAG_W];

  logic [TAG_W-1:0]  tagMem  [SETS][WAYS];
  logic [DATA_W-1:0] dataMem [SETS][WAYS][BYTES];
  logic [WAYS-1:0]   validMem [SETS];
  logic [SETS-1:0]   lruBits;

  logic [WAYS-1:0]   wayHit;
  logic [DATA_W-1:0] wayByte [WAYS];

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign wayHit[w]  = validMem[curSet][w] && (tagMem[curSet][w] == curTag);
      assign wayByte[w] = dataMem[curSet][w][curOff];
    end
  endgenerate

  logic              hitWay;
  logic [DATA_W-1:0] hitByte;
  assign lookupHit = |wayHit;
  assign hitWay    = wayHit[1];
  assign hitByte   = hitWay ? wayByte[1] : wayByte[0];

  logic [WAYS-1:0] setValid;
  logic            victimNext;
  assign setValid = validMem[curSet];
  always_comb begin
    if (!setValid[0])      victimNext = 1'b0;
    else if (!setValid[1]) victimNext = 1'b1;
    else                   victimNext = lruBits[curSet];
  end

  logic              victimWay;
  logic [OFF_W-1:0]  fillCnt;
  logic [DATA_W-1:0] missByte;

  assign lastByte  = (fillCnt == OFF_LAST);
  assign blockAddr = {curTag, curSet, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
      lruBits   <= '0;
      curAddr   <= '0;
      victimWay <= 1'b0;
      fillCnt   <= '0;
      missByte  <= '0;
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspData   <= '0;
    end else begin
      rspValid <= 1'b0;
      if (strobe.capture) curAddr <= reqAddr;
      if (strobe.hitTouch) begin
        lruBits[curSet] <= ~hitWay;
        rspValid        <= 1'b1;
        rspHit          <= 1'b1;
        rspData         <= hitByte;
      end
      if (strobe.missPick) begin
        victimWay <= victimNext;
        fillCnt   <= '0;
      end
      if (strobe.fillByte) begin
        fillCnt <= fillCnt + OFF_ONE;
        if (fillCnt == curOff) missByte <= memData;
      end
      if (strobe.fillLast) begin
        validMem[curSet][victimWay] <= 1'b1;
        lruBits[curSet]             <= ~victimWay;
        rspValid                    <= 1'b1;
        rspHit                      <= 1'b0;
        rspData                     <= (fillCnt == curOff) ? memData : missByte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillByte) dataMem[curSet][victimWay][fillCnt] <= memData;
    if (strobe.fillLast) tagMem[curSet][victimWay] <= curTag;
  end

  assert_one_way_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hitTouch |-> $countones(wayHit) <= 1);

  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_fill_marks_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillLast |=> validMem[curSet][victimWay]);

  assert_invalid_way_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.missPick && setValid == 2'b01) |=> victimWay == 1'b1);
endmodule

// File: rtl/cache2way_ctrl.sv
module cache2way_ctrl
  import cache2way_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lookupHit,
  input  logic        lastByte,
  input  logic        memAck,
  input  logic        memDataValid,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        memReq
);
  ctrlState_t state, stateNext;

  always_comb begin
    strobe          = '0;
    strobe.capture  = (state == ST_IDLE) && reqValid;
    strobe.hitTouch = (state == ST_LOOKUP) && lookupHit;
    strobe.missPick = (state == ST_LOOKUP) && !lookupHit;
    strobe.fillByte = (state == ST_FILL) && memDataValid;
    strobe.fillLast = (state == ST_FILL) && memDataValid && lastByte;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_LOOKUP;
      ST_LOOKUP: stateNext = lookupHit ? ST_IDLE : ST_FETCH;
      ST_FETCH:  if (memAck) stateNext = ST_FILL;
      ST_FILL:   if (memDataValid && lastByte) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign memReq   = (state == ST_FETCH);

  assert_ack_starts_fill_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (!memReq && !reqReady));
endmodule

// File: rtl/cache2way.sv
module cache2way
  import cache2way_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int SET_W  = 2,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic [TAG_W+SET_W+OFF_W-1:0] reqAddr,
  output logic                         reqReady,
  output logic                         rspValid,
  output logic                         rspHit,
  output logic [DATA_W-1:0]            rspData,
  output logic                         memReq,
  output logic [TAG_W+SET_W+OFF_W-1:0] memAddr,
  input  logic                         memAck,
  input  logic                         memDataValid,
  input  logic [DATA_W-1:0]            memData
);
  ctrlStrobe_t strobe;
  logic lookupHit;
  logic lastByte;

  cache2way_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .lookupHit    (lookupHit),
    .lastByte     (lastByte),
    .memAck       (memAck),
    .memDataValid (memDataValid),
    .strobe       (strobe),
    .reqReady     (reqReady),
    .memReq       (memReq)
  );

  cache2way_dp #(
    .TAG_W  (TAG_W),
    .SET_W  (SET_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .memData   (memData),
    .lookupHit (lookupHit),
    .lastByte  (lastByte),
    .blockAddr (memAddr),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspData   (rspData)
  );

  assert_fetch_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  assert_no_rsp_in_fetch_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (!rspValid && !reqReady));
endmodule

// File: tb/tb_cache2way.sv
module tb_cache2way;
  localparam int TAG_W  = 4;
  localparam int SET_W  = 2;
  localparam int OFF_W  = 2;
  localparam int DATA_W = 8;
  localparam int ADDR_W = TAG_W + SET_W + OFF_W;
  localparam int BYTES  = 1 << OFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqReady, rspValid, rspHit, memReq;
  logic [DATA_W-1:0] rspData;
  logic [ADDR_W-1:0] memAddr;
  logic memAck = 1'b0;
  logic memDataValid = 1'b0;
  logic [DATA_W-1:0] memData = '0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cache2way #(.TAG_W(TAG_W), .SET_W(SET_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memDataValid(memDataValid), .memData(memData)
  );

  function automatic logic [DATA_W-1:0] memByte(logic [ADDR_W-1:0] a);
    return DATA_W'(a * 37 + 11);
  endfunction

  function automatic logic [ADDR_W-1:0] mkAddr(int tag, int set, int off);
    return {tag[TAG_W-1:0], set[SET_W-1:0], off[OFF_W-1:0]};
  endfunction

  task automatic chkEq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(logic [ADDR_W-1:0] a, bit expHit, string req,
                        logic [3:0] gapMask, int ackDelay);
    logic [ADDR_W-1:0] base;
    int  cycles;
    bit  done;
    bit  sawMiss;
    base = a & ~ADDR_W'(BYTES - 1);
    @(negedge clk);
    chkEq("R5", "ready before request", int'(reqReady), 1);
    reqValid = 1'b1;
    reqAddr  = a;
    @(negedge clk);
    reqValid = 1'b0;
    cycles = 0; done = 0; sawMiss = 0;
    while (!done && cycles < 200) begin
      @(negedge clk);
      cycles++;
      if (rspValid) done = 1;
      else if (memReq && !sawMiss) begin
        sawMiss = 1;
        chkEq("R5", "fetch address", int'(memAddr), int'(base));
        chkEq("R5", "stall during fetch", int'(reqReady), 0);
        for (int d = 0; d < ackDelay; d++) begin
          @(negedge clk);
          cycles++;
          chkEq("R5", "request held", int'(memReq), 1);
          chkEq("R5", "address held", int'(memAddr), int'(base));
        end
        memAck = 1'b1;
        @(negedge clk);
        memAck = 1'b0;
        for (int i = 0; i < BYTES; i++) begin
          if (gapMask[i]) begin
            memDataValid = 1'b0;
            memData = 8'hEE;
            @(negedge clk);
          end
          memDataValid = 1'b1;
          memData = memByte(base + ADDR_W'(i));
          @(negedge clk);
        end
        memDataValid = 1'b0;
        if (rspValid) done = 1;
      end
    end
    if (!done) begin
      chkEq(req, "response timeout", 0, 1);
    end else begin
      chkEq(req, "hit flag", int'(rspHit), int'(expHit));
      chkEq(req, "data byte", int'(rspData), int'(memByte(a)));
      chkEq(req, "memory fetch occurred", int'(sawMiss), int'(!expHit));
      if (expHit) chkEq("R3", "hit latency", cycles, 1);
      @(negedge clk);
      chkEq("R3", "single-cycle response", int'(rspValid), 0);
    end
  endtask

  // R2 reset state and cold miss
  task automatic t_reset;
    chkEq("R2", "ready after reset", int'(reqReady), 1);
    chkEq("R2", "no response after reset", int'(rspValid), 0);
    chkEq("R2", "no fetch after reset", int'(memReq), 0);
  endtask

  // R1 R6: cold miss with gaps, then every offset placed correctly
  task automatic t_coldFill;
    access(mkAddr(1, 0, 2), 1'b0, "R2", 4'b0101, 2);
    for (int o = 0; o < BYTES; o++) access(mkAddr(1, 0, o), 1'b1, "R6", 4'b0000, 0);
  endtask

  // R7: two invalid lines take two different blocks
  task automatic t_invalidFirst;
    access(mkAddr(2, 1, 0), 1'b0, "R7", 4'b0000, 0);
    access(mkAddr(3, 1, 3), 1'b0, "R7", 4'b1000, 1);
    access(mkAddr(2, 1, 1), 1'b1, "R7", 4'b0000, 0);
    access(mkAddr(3, 1, 2), 1'b1, "R7", 4'b0000, 0);
  endtask

  // R8 R4: a hit protects its line from the next eviction
  task automatic t_hitRefresh;
    access(mkAddr(2, 1, 0), 1'b1, "R8", 4'b0000, 0);
    access(mkAddr(4, 1, 1), 1'b0, "R8", 4'b0010, 0);
    access(mkAddr(2, 1, 3), 1'b1, "R8", 4'b0000, 0);
    access(mkAddr(4, 1, 0), 1'b1, "R4", 4'b0000, 0);
    access(mkAddr(3, 1, 0), 1'b0, "R8", 4'b0000, 3);
  endtask

  // R9: classic two-line sequence
  task automatic t_sequence;
    access(mkAddr(1, 2, 0), 1'b0, "R9", 4'b0000, 0);
    access(mkAddr(2, 2, 1), 1'b0, "R9", 4'b0000, 0);
    access(mkAddr(1, 2, 2), 1'b1, "R9", 4'b0000, 0);
    access(mkAddr(3, 2, 3), 1'b0, "R9", 4'b0100, 0);
    access(mkAddr(2, 2, 0), 1'b0, "R9", 4'b0000, 1);
    access(mkAddr(1, 2, 1), 1'b0, "R9", 4'b0000, 0);
    access(mkAddr(2, 2, 2), 1'b1, "R9", 4'b0000, 0);
  endtask

  // R1: sets are independent, tag alone is not enough
  task automatic t_setIsolation;
    access(mkAddr(6, 3, 0), 1'b0, "R1", 4'b0000, 0);
    access(mkAddr(7, 3, 1), 1'b0, "R1", 4'b0000, 0);
    access(mkAddr(8, 3, 2), 1'b0, "R1", 4'b0000, 0);
    access(mkAddr(1, 0, 3), 1'b1, "R1", 4'b0000, 0);
    access(mkAddr(1, 3, 3), 1'b0, "R1", 4'b0000, 0);
  endtask

  // R10: stray memory strobes while idle change nothing
  task automatic t_strayStrobes;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      memDataValid = 1'b1;
      memAck = i[0];
      memData = 8'h00;
      @(negedge clk);
      chkEq("R10", "no response to stray strobe", int'(rspValid), 0);
    end
    memDataValid = 1'b0;
    memAck = 1'b0;
    for (int o = 0; o < BYTES; o++) access(mkAddr(1, 0, o), 1'b1, "R10", 4'b0000, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_coldFill();
    t_invalidFirst();
    t_hitRefresh();
    t_sequence();
    t_setIsolation();
    t_strayStrobes();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule